// File: doc/BRIEF.md
# Configurable-Format Serial Character Transmitter

This block turns one character per write into an asynchronous serial frame on a single line that rests high. A host loads a character into a one-entry holding register with a write strobe. The block then moves it into a shift register and sends a low start bit, then the data bits with the least significant bit first. An optional parity bit follows, then a high stop interval. Bit timing comes from an external one-cycle enable pulse that runs at sixteen times the bit rate, so every serial bit lasts sixteen of those pulses.

The frame format is chosen at run time. The character length can be 5 to 8 bits. Parity can be even, odd, off, or forced to a constant (stick). The stop interval is either short or long. The format inputs are captured when a frame is launched. While a frame is on the line, software can load the next character and the next format. A holding-empty flag tells software when the holding register can take another character. A busy flag covers the whole time a frame is on the line. When the stop interval ends and a character is waiting, the next start bit follows with no idle gap.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1, `tx_busy` is 0, and once reset ends `hold_empty` is 1 while nothing is pending.
- R2: A write on `wr_en` clears `hold_empty` on the next cycle. If the transmitter is idle, the following cycle launches the frame: `hold_empty` returns to 1, `tx_busy` becomes 1 and `tx_line` drives the low start bit.
- R3: After the start bit come the data bits, `wr_data[0]` first. The number of data bits is 5 + `len_sel`, so `len_sel` = 0, 1, 2, 3 gives 5, 6, 7, 8 bits. Data bits above that length are not sent.
- R4: Every start, data and parity bit lasts exactly 16 cycles in which `baud_tick` is 1. While `baud_tick` is 0 the line and the busy flag do not change.
- R5: When `par_en` is 1 and `par_stick` is 0, one parity bit follows the last data bit. With `par_even` = 1 the data bits plus the parity bit hold an even number of ones. With `par_even` = 0 they hold an odd number. When `par_en` is 0, no parity bit is sent.
- R6: When `par_en` and `par_stick` are both 1, the parity bit is constant: 0 if `par_even` is 1 and 1 if `par_even` is 0.
- R7: The stop interval is high. It lasts 16 ticks when `stop_long` is 0. When `stop_long` is 1 it lasts 24 ticks for 5-bit characters and 32 ticks for 6 to 8 bit characters.
- R8: `hold_empty` rises in the cycle the character moves into the shift register, and stays 0 while a written character waits. If a character is waiting when the stop interval ends, the next start bit begins in the very next cycle.
- R9: The format inputs (`len_sel`, `par_en`, `par_even`, `par_stick`, `stop_long`) are sampled at frame launch. Changing them during a frame does not alter that frame.
- R10: `tx_busy` stays 1 from the launch cycle until the last stop tick, including across back-to-back frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| len_sel | input | 2 | Data length code, 5 + value bits |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select; stick value select |
| par_stick | input | 1 | Force parity to a constant |
| stop_long | input | 1 | Long stop interval select |
| tx_line | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register can accept a character |
| tx_busy | output | 1 | A frame is on the line |

## Verification
A bad bit counter or bit index shows up as a frame whose start-to-start spacing is off by a multiple of 16 ticks. It also shows up as data sampled at mid-bit that is shifted by one position, and this is visible within the first frame after the fault. A wrong state for the captured format or the parity register appears at the parity or stop sample of the frame itself, and also in the next frame's spacing. A fault in the holding register handshake shows up within one or two cycles of a write, through `hold_empty` and the delay to the start bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned SX_DATA_W = 8;
    localparam int unsigned SX_LEN_W  = 2;
    localparam int unsigned SX_OSR    = 16;

    typedef logic [SX_DATA_W-1:0] sx_data_t;

    typedef enum logic [2:0] {
        SX_IDLE,
        SX_START,
        SX_DATA,
        SX_PAR,
        SX_STOP
    } sx_state_e;

    typedef enum logic [1:0] {
        SX_STOP_ONE,
        SX_STOP_ONE_HALF,
        SX_STOP_TWO
    } sx_stop_e;

    typedef struct packed {
        logic [SX_LEN_W-1:0] len_code;
        logic                par_en;
        logic                par_even;
        logic                par_stick;
        logic                stop_long;
    } sx_cfg_t;

    // mask that keeps only the bits within the selected character length
    function automatic sx_data_t sx_mask(logic [SX_LEN_W-1:0] code);
        return {SX_DATA_W{1'b1}} >> (2'd3 - code);
    endfunction

    function automatic logic sx_parity(sx_cfg_t c, sx_data_t d);
        logic ones_odd;
        ones_odd = ^(d & sx_mask(c.len_code));
        if (c.par_stick) return ~c.par_even;
        return c.par_even ? ones_odd : ~ones_odd;
    endfunction

    function automatic sx_stop_e sx_stop_kind(logic long_sel, logic [SX_LEN_W-1:0] code);
        if (!long_sel)       return SX_STOP_ONE;
        if (code == '0)      return SX_STOP_ONE_HALF;
        return SX_STOP_TWO;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  sx_data_t wr_data,
    input  logic     take,
    output logic     full,
    output sx_data_t data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_en) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    p_write_fills_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> full);

    p_take_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (take && !wr_en) |=> !full);

endmodule

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             bit_end
);

    logic [CNT_W-1:0] cnt;

    assign bit_end = tick && !clear && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clear || bit_end) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit);

    p_cnt_waits_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
    import sertx_pkg::*;
#(
    parameter int unsigned OSR = SX_OSR
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     hold_full,
    input  sx_data_t hold_data,
    input  sx_cfg_t  cfg_in,
    output logic     take,
    output logic     txd,
    output logic     busy
);

    localparam int unsigned CNT_W = $clog2(2 * OSR);
    localparam int unsigned IDX_W = $clog2(SX_DATA_W);
    localparam logic [CNT_W-1:0] LIM_BIT  = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] LIM_S15  = CNT_W'(OSR + OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LIM_S2   = CNT_W'(2 * OSR - 1);
    localparam logic [IDX_W-1:0] IDX_BASE = IDX_W'(SX_DATA_W - 4);

    sx_state_e           state;
    sx_data_t            shreg;
    logic                par_q;
    logic [SX_LEN_W-1:0] len_q;
    logic                pen_q;
    sx_stop_e            stop_q;
    logic [IDX_W-1:0]    bidx;
    logic [IDX_W-1:0]    last_idx;
    logic [CNT_W-1:0]    limit;
    logic                bit_end;
    logic                launch;

    assign last_idx = IDX_BASE + IDX_W'(len_q);

    always_comb begin
        limit = LIM_BIT;
        if (state == SX_STOP) begin
            unique case (stop_q)
                SX_STOP_ONE_HALF: limit = LIM_S15;
                SX_STOP_TWO:      limit = LIM_S2;
                default:          limit = LIM_BIT;
            endcase
        end
    end

    sertx_bitclk #(.CNT_W(CNT_W)) bitclk_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (state == SX_IDLE),
        .tick    (tick),
        .limit   (limit),
        .bit_end (bit_end)
    );

    assign launch = hold_full &&
                    ((state == SX_IDLE) || (state == SX_STOP && bit_end));
    assign take   = launch;
    assign busy   = (state != SX_IDLE);

    always_comb begin
        unique case (state)
            SX_START: txd = 1'b0;
            SX_DATA:  txd = shreg[0];
            SX_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SX_IDLE;
            shreg  <= '0;
            par_q  <= 1'b0;
            len_q  <= '0;
            pen_q  <= 1'b0;
            stop_q <= SX_STOP_ONE;
            bidx   <= '0;
        end else if (launch) begin
            state  <= SX_START;
            shreg  <= hold_data & sx_mask(cfg_in.len_code);
            par_q  <= sx_parity(cfg_in, hold_data);
            len_q  <= cfg_in.len_code;
            pen_q  <= cfg_in.par_en;
            stop_q <= sx_stop_kind(cfg_in.stop_long, cfg_in.len_code);
            bidx   <= '0;
        end else if (bit_end) begin
            unique case (state)
                SX_START: begin
                    state <= SX_DATA;
                    bidx  <= '0;
                end
                SX_DATA: begin
                    shreg <= shreg >> 1;
                    if (bidx == last_idx) begin
                        state <= pen_q ? SX_PAR : SX_STOP;
                    end else begin
                        bidx <= bidx + 1'b1;
                    end
                end
                SX_PAR:  state <= SX_STOP;
                default: state <= SX_IDLE;
            endcase
        end
    end

    p_bit_index_r3: assert property (@(posedge clk) disable iff (rst)
        (state == SX_DATA) |-> (bidx <= last_idx));

    p_launch_start_r2: assert property (@(posedge clk) disable iff (rst)
        (state == SX_IDLE && hold_full) |=> (state == SX_START && !txd));

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !launch) |=> ($stable(len_q) && $stable(pen_q) && $stable(stop_q) && $stable(par_q)));

    p_parity_slot_r5: assert property (@(posedge clk) disable iff (rst)
        (state == SX_PAR) |-> pen_q);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int unsigned OSR = SX_OSR
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 baud_tick,
    input  logic                 wr_en,
    input  logic [SX_DATA_W-1:0] wr_data,
    input  logic [SX_LEN_W-1:0]  len_sel,
    input  logic                 par_en,
    input  logic                 par_even,
    input  logic                 par_stick,
    input  logic                 stop_long,
    output logic                 tx_line,
    output logic                 hold_empty,
    output logic                 tx_busy
);

    sx_cfg_t  cfg;
    sx_data_t hold_data;
    logic     hold_full;
    logic     take;

    assign cfg = '{len_code: len_sel, par_en: par_en, par_even: par_even,
                   par_stick: par_stick, stop_long: stop_long};

    sertx_hold hold_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    sertx_frame #(.OSR(OSR)) frame_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .cfg_in    (cfg),
        .take      (take),
        .txd       (tx_line),
        .busy      (tx_busy)
    );

    assign hold_empty = ~hold_full;

    p_idle_line_r1: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> tx_line);

    p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && !baud_tick) |=> ($stable(tx_line) && tx_busy));

    p_busy_on_take_r10: assert property (@(posedge clk) disable iff (rst)
        take |=> tx_busy);

endmodule

// File: tb/sertx_top_tb_top.sv
`timescale 1ns/1ps
module sertx_top_tb_top;

    typedef struct packed {
        logic [1:0] len;
        logic       pen;
        logic       peven;
        logic       pstick;
        logic       slong;
        logic [7:0] data;
        logic       exp_par;
        logic [8:0] exp_ticks;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 9'd160},
        '{2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h3F, 1'b1, 9'd136},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hC7, 1'b0, 9'd160},
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'h55, 1'b0, 9'd160},
        '{2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 9'd192},
        '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h03, 1'b1, 9'd160},
        '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 9'd176}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] len_sel = 2'd3;
    logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, stop_long = 1'b0;
    logic       tx_line, hold_empty, tx_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cyc = 0;
    logic [1:0] tick_mode = 2'd0;
    logic [1:0] ph = 2'd0;
    int start_at [NV];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        ph <= ph + 2'd1;
        baud_tick <= (tick_mode == 2'd1) || (tick_mode == 2'd2 && ph == 2'd3);
    end

    sertx_top dut_i (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .len_sel(len_sel), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .stop_long(stop_long), .tx_line(tx_line), .hold_empty(hold_empty), .tx_busy(tx_busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input vec_t v);
        len_sel = v.len; par_en = v.pen; par_even = v.peven;
        par_stick = v.pstick; stop_long = v.slong;
    endtask

    task automatic driver();
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_cfg(VECS[i]);
            wr_en = 1'b1; wr_data = VECS[i].data;
            @(negedge clk);
            wr_en = 1'b0;
            while (!hold_empty) @(negedge clk);
        end
    endtask

    task automatic monitor();
        for (int k = 0; k < NV; k++) begin
            logic [7:0] rx;
            logic [7:0] mask;
            int nbits;
            rx = '0;
            nbits = 5 + int'(VECS[k].len);
            mask = 8'hFF >> (3 - VECS[k].len);
            @(negedge clk);
            while (tx_line !== 1'b0) @(negedge clk);
            start_at[k] = cyc;
            repeat (8) @(negedge clk);
            chk("R2", $sformatf("frame %0d start bit", k), tx_line, 0);
            for (int j = 0; j < nbits; j++) begin
                repeat (16) @(negedge clk);
                rx[j] = tx_line;
            end
            chk("R3", $sformatf("frame %0d data", k), rx, VECS[k].data & mask);
            if (VECS[k].pen) begin
                repeat (16) @(negedge clk);
                chk(VECS[k].pstick ? "R6" : "R5", $sformatf("frame %0d parity", k),
                    tx_line, VECS[k].exp_par);
            end
            repeat (16) @(negedge clk);
            chk("R7", $sformatf("frame %0d stop level", k), tx_line, 1);
        end
        while (tx_busy) @(negedge clk);
        chk("R10", "last frame busy span", cyc - start_at[NV-1], VECS[NV-1].exp_ticks);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c1, c2;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset line", tx_line, 1);
        chk("R1", "reset busy", tx_busy, 0);
        chk("R1", "reset empty", hold_empty, 1);

        // vector table, tick every cycle; format changes mid-frame (R9)
        tick_mode = 2'd1;
        fork
            driver();
            monitor();
        join
        for (int k = 0; k < NV - 1; k++)
            chk(VECS[k].slong ? "R7" : "R8", $sformatf("frame %0d start-to-start ticks (R4 R9)", k),
                start_at[k+1] - start_at[k], VECS[k].exp_ticks);
        chk("R1", "idle after table", tx_line, 1);

        // handshake with ticks stopped
        tick_mode = 2'd0;
        repeat (3) @(negedge clk);
        set_cfg(VECS[0]);
        wr_en = 1'b1; wr_data = 8'h0F;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2", "empty after write", hold_empty, 0);
        chk("R2", "not yet busy", tx_busy, 0);
        @(negedge clk);
        chk("R8", "empty after move", hold_empty, 1);
        chk("R10", "busy at launch", tx_busy, 1);
        chk("R2", "start bit at launch", tx_line, 0);
        repeat (40) @(negedge clk);
        chk("R4", "line frozen without ticks", tx_line, 0);
        chk("R4", "busy frozen without ticks", tx_busy, 1);
        wr_en = 1'b1; wr_data = 8'h33;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8", "pending char keeps empty low", hold_empty, 0);
        tick_mode = 2'd2;
        while (!hold_empty) @(negedge clk);
        c1 = cyc;
        chk("R8", "back-to-back start bit", tx_line, 0);
        chk("R10", "busy across frames", tx_busy, 1);
        set_cfg(VECS[1]);
        while (tx_busy) @(negedge clk);
        c2 = cyc;
        chk("R9", "sparse-tick frame length (R4)", c2 - c1, 640);
        chk("R1", "idle line at end", tx_line, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule